// File: doc/BRIEF.md
# 64-bit SECDED Check and Correction Unit

This unit protects a 64-bit datapath with an 8-bit check byte built from a fixed, irregular parity-check matrix. The word is presented as an upper and a lower 32-bit half. The unit always produces the check byte for the presented word, so a write path can store it. On a read path the caller also supplies the stored check byte. The unit then forms the syndrome and classifies the error. It can name a single faulty data bit, name a single faulty check bit, or flag the pattern as uncorrectable. It also returns the word with any located data fault repaired.

The unit does not use a Hamming position code. It finds a faulty bit by comparing the syndrome against every data column of the matrix. A data-column match takes priority. Only when no data column matches is the syndrome read as a check-bit fault. All results pass through one register stage, and a valid strobe travels alongside them.

Top module: `ecc64_secded_unit`

## Requirements
- R1: Check bit k (k = 0..7) is the XOR of the data bits selected by mask pair k. The first mask of the pair selects from bits 63:32 (mask bit j selects data bit 32+j). The second mask selects from bits 31:0. In hex, the pairs for k = 0..7 are: (F00FE11E, C33C0FF7), (00FF00FF, 00FFF0FF), (0F0F0F0F, 0F0FFF00), (11113333, 7777000F), (22224444, 8888222F), (44448888, FFFF4441), (8888FFFF, 11118882), (FFFF1111, 22221114).
- R2: The syndrome output equals the generated check byte XOR the stored check byte.
- R3: The column of data bit b has, at bit k, mask bit (b mod 32) of pair k: from the upper mask when b ≥ 32, otherwise from the lower mask. If a non-zero syndrome equals some column, the data-fault flag is set and its 6-bit index gives that bit. If several columns match, the lowest bit number is given. The check-fault and uncorrectable flags stay low.
- R4: When a data fault is located, the corrected word is the input word with exactly that bit inverted.
- R5: A zero syndrome raises no flag. Both indices read 0, and the corrected word equals the input word.
- R6: A syndrome that matches no data column and has exactly one bit set raises the check-fault flag. Its 3-bit index gives the position of the set bit. The data-fault index reads 0 and the word passes through unchanged.
- R7: Any other non-zero syndrome raises only the uncorrectable flag. Both indices read 0 and the word is unchanged.
- R8: valid_out equals valid_in one clock earlier. All result outputs load only in cycles with valid_in high and hold their values otherwise.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Input word and stored check byte are valid |
| data_hi | input | 32 | Data bits 63:32 |
| data_lo | input | 32 | Data bits 31:0 |
| chk_stored | input | 8 | Check byte read with the word |
| valid_out | output | 1 | Results below are from the previous valid input |
| chk_gen | output | 8 | Check byte generated from the data |
| syndrome | output | 8 | chk_gen XOR stored check byte |
| data_fault | output | 1 | A single data bit was located |
| data_fault_idx | output | 6 | Located data bit number |
| chk_fault | output | 1 | A single check bit was located |
| chk_fault_idx | output | 3 | Located check bit number |
| uncorrectable | output | 1 | Non-zero syndrome that cannot be located |
| data_fixed | output | 64 | Word with any located data bit repaired |

## Verification
Because the unit is a single stage, a wrong mask bit, comparator or priority decision shows up on the ports in the cycle right after the faulty word is applied. It appears as a wrong check byte, a wrong syndrome, a wrong flag or index, or a corrected word that differs in the wrong bit. The reference model sweeps every data-bit and check-bit flip, double flips and random words. This makes every matrix column and every classification branch visible at the outputs. Idle cycles with changing inputs expose any result register that fails to hold.

// File: rtl/ecc64_pkg.sv
package ecc64_pkg;

    localparam int HALF_W  = 32;
    localparam int DATA_W  = 2 * HALF_W;
    localparam int CHK_W   = 8;
    localparam int DIDX_W  = $clog2(DATA_W);
    localparam int CIDX_W  = $clog2(CHK_W);

    // selection masks per check bit, index = check bit number
    localparam logic [0:CHK_W-1][HALF_W-1:0] SEL_UPPER = {
        32'hF00FE11E, 32'h00FF00FF, 32'h0F0F0F0F, 32'h11113333,
        32'h22224444, 32'h44448888, 32'h8888FFFF, 32'hFFFF1111
    };
    localparam logic [0:CHK_W-1][HALF_W-1:0] SEL_LOWER = {
        32'hC33C0FF7, 32'h00FFF0FF, 32'h0F0FFF00, 32'h7777000F,
        32'h8888222F, 32'hFFFF4441, 32'h11118882, 32'h22221114
    };

    // syndrome produced by a single fault on data bit b
    function automatic logic [CHK_W-1:0] column_of(input int b);
        logic [CHK_W-1:0] c;
        for (int k = 0; k < CHK_W; k++) begin
            if (b >= HALF_W) c[k] = SEL_UPPER[k][b - HALF_W];
            else             c[k] = SEL_LOWER[k][b];
        end
        return c;
    endfunction

    typedef struct packed {
        logic              vld;
        logic [CHK_W-1:0]  gen;
        logic [CHK_W-1:0]  syn;
        logic              derr;
        logic [DIDX_W-1:0] didx;
        logic              cerr;
        logic [CIDX_W-1:0] cidx;
        logic              unc;
        logic [DATA_W-1:0] word;
    } ecc_result_t;

endpackage

// File: rtl/ecc64_checkgen.sv
module ecc64_checkgen
    import ecc64_pkg::*;
(
    input  logic [HALF_W-1:0] upper,
    input  logic [HALF_W-1:0] lower,
    output logic [CHK_W-1:0]  check
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_bit
        assign check[k] = (^(upper & SEL_UPPER[k])) ^ (^(lower & SEL_LOWER[k]));
    end
endmodule

// File: rtl/ecc64_locator.sv
module ecc64_locator
    import ecc64_pkg::*;
(
    input  logic [CHK_W-1:0]  syn,
    output logic              dhit,
    output logic [DIDX_W-1:0] didx,
    output logic              chit,
    output logic [CIDX_W-1:0] cidx,
    output logic              unc
);
    logic [DATA_W-1:0] col_match;
    logic              nonzero;
    logic              single;

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        localparam logic [CHK_W-1:0] COL = column_of(b);
        assign col_match[b] = (syn == COL);
    end

    assign nonzero = |syn;
    assign single  = nonzero && ((syn & (syn - 1'b1)) == '0);

    always_comb begin
        didx = '0;
        // descending scan leaves the lowest matching bit
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (col_match[b]) didx = DIDX_W'(b);
        end
    end

    always_comb begin
        cidx = '0;
        for (int k = 0; k < CHK_W; k++) begin
            if (syn[k]) cidx = CIDX_W'(k);
        end
    end

    logic raw_dhit;
    assign raw_dhit = nonzero && (|col_match);
    assign dhit     = raw_dhit;
    assign chit     = !raw_dhit && single;
    assign unc      = nonzero && !raw_dhit && !single;
endmodule

// File: rtl/ecc64_corrector.sv
module ecc64_corrector
    import ecc64_pkg::*;
(
    input  logic [DATA_W-1:0] word_in,
    input  logic              flip_en,
    input  logic [DIDX_W-1:0] flip_idx,
    output logic [DATA_W-1:0] word_out
);
    always_comb begin
        word_out = word_in;
        if (flip_en) word_out[flip_idx] = ~word_in[flip_idx];
    end
endmodule

// File: rtl/ecc64_secded_unit.sv
module ecc64_secded_unit
    import ecc64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [HALF_W-1:0] data_hi,
    input  logic [HALF_W-1:0] data_lo,
    input  logic [CHK_W-1:0]  chk_stored,
    output logic              valid_out,
    output logic [CHK_W-1:0]  chk_gen,
    output logic [CHK_W-1:0]  syndrome,
    output logic              data_fault,
    output logic [DIDX_W-1:0] data_fault_idx,
    output logic              chk_fault,
    output logic [CIDX_W-1:0] chk_fault_idx,
    output logic              uncorrectable,
    output logic [DATA_W-1:0] data_fixed
);
    logic [CHK_W-1:0]  gen_w;
    logic [CHK_W-1:0]  syn_w;
    logic              dhit_w, chit_w, unc_w;
    logic [DIDX_W-1:0] didx_w;
    logic [CIDX_W-1:0] cidx_w;
    logic [DATA_W-1:0] fixed_w;
    ecc_result_t       res_d, res_q;

    ecc64_checkgen u_gen (
        .upper (data_hi),
        .lower (data_lo),
        .check (gen_w)
    );

    assign syn_w = gen_w ^ chk_stored;

    ecc64_locator u_loc (
        .syn  (syn_w),
        .dhit (dhit_w),
        .didx (didx_w),
        .chit (chit_w),
        .cidx (cidx_w),
        .unc  (unc_w)
    );

    ecc64_corrector u_fix (
        .word_in  ({data_hi, data_lo}),
        .flip_en  (dhit_w),
        .flip_idx (didx_w),
        .word_out (fixed_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = valid_in;
        if (valid_in) begin
            res_d.gen  = gen_w;
            res_d.syn  = syn_w;
            res_d.derr = dhit_w;
            res_d.didx = dhit_w ? didx_w : '0;
            res_d.cerr = chit_w;
            res_d.cidx = chit_w ? cidx_w : '0;
            res_d.unc  = unc_w;
            res_d.word = fixed_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_out      = res_q.vld;
    assign chk_gen        = res_q.gen;
    assign syndrome       = res_q.syn;
    assign data_fault     = res_q.derr;
    assign data_fault_idx = res_q.didx;
    assign chk_fault      = res_q.cerr;
    assign chk_fault_idx  = res_q.cidx;
    assign uncorrectable  = res_q.unc;
    assign data_fixed     = res_q.word;
endmodule

// File: rtl/ecc64_secded_chk.sv
module ecc64_secded_chk
    import ecc64_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [HALF_W-1:0] data_hi,
    input logic [HALF_W-1:0] data_lo,
    input logic [CHK_W-1:0]  chk_stored,
    input logic              valid_out,
    input logic [CHK_W-1:0]  chk_gen,
    input logic [CHK_W-1:0]  syndrome,
    input logic              data_fault,
    input logic [DIDX_W-1:0] data_fault_idx,
    input logic              chk_fault,
    input logic [CIDX_W-1:0] chk_fault_idx,
    input logic              uncorrectable,
    input logic [DATA_W-1:0] data_fixed
);
    // R2
    syn_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> syndrome == (chk_gen ^ $past(chk_stored)));

    // R4
    fix_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (data_fault
            ? $countones(data_fixed ^ $past({data_hi, data_lo})) == 1
            : data_fixed == $past({data_hi, data_lo})));

    // R5
    clean_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && syndrome == '0) |-> !data_fault && !chk_fault && !uncorrectable);

    // R6
    chk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fault |-> ($countones(syndrome) == 1 && syndrome[chk_fault_idx] && !data_fault));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_fault, chk_fault, uncorrectable}));

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(valid_in));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(syndrome) && $stable(data_fixed) && $stable(chk_gen));

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_out_chk: assert (!valid_out && !data_fault && !chk_fault && !uncorrectable);
        end
    end
endmodule

bind ecc64_secded_unit ecc64_secded_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_in       (valid_in),
    .data_hi        (data_hi),
    .data_lo        (data_lo),
    .chk_stored     (chk_stored),
    .valid_out      (valid_out),
    .chk_gen        (chk_gen),
    .syndrome       (syndrome),
    .data_fault     (data_fault),
    .data_fault_idx (data_fault_idx),
    .chk_fault      (chk_fault),
    .chk_fault_idx  (chk_fault_idx),
    .uncorrectable  (uncorrectable),
    .data_fixed     (data_fixed)
);

// File: tb/tb_ecc64_secded_unit.sv
module tb_ecc64_secded_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] data_hi = '0;
    logic [31:0] data_lo = '0;
    logic [7:0]  chk_stored = '0;
    logic        valid_out;
    logic [7:0]  chk_gen, syndrome;
    logic        data_fault, chk_fault, uncorrectable;
    logic [5:0]  data_fault_idx;
    logic [2:0]  chk_fault_idx;
    logic [63:0] data_fixed;

    always #10 clk = ~clk;   // 50 MHz

    ecc64_secded_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .data_hi(data_hi), .data_lo(data_lo), .chk_stored(chk_stored),
        .valid_out(valid_out), .chk_gen(chk_gen), .syndrome(syndrome),
        .data_fault(data_fault), .data_fault_idx(data_fault_idx),
        .chk_fault(chk_fault), .chk_fault_idx(chk_fault_idx),
        .uncorrectable(uncorrectable), .data_fixed(data_fixed)
    );

    // matrix from R1
    logic [31:0] up_m [8] = '{32'hF00FE11E, 32'h00FF00FF, 32'h0F0F0F0F, 32'h11113333,
                              32'h22224444, 32'h44448888, 32'h8888FFFF, 32'hFFFF1111};
    logic [31:0] lo_m [8] = '{32'hC33C0FF7, 32'h00FFF0FF, 32'h0F0FFF00, 32'h7777000F,
                              32'h8888222F, 32'hFFFF4441, 32'h11118882, 32'h22221114};

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected outputs
    logic        e_vld;
    logic [7:0]  e_gen, e_syn;
    logic        e_derr, e_cerr, e_unc;
    int          e_didx, e_cidx;
    logic [63:0] e_word;
    string       e_tag, e_fix_tag;

    function automatic logic [7:0] ref_check(logic [31:0] h, logic [31:0] l);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 32; j++) begin
                if (up_m[k][j]) r[k] = r[k] ^ h[j];
                if (lo_m[k][j]) r[k] = r[k] ^ l[j];
            end
        return r;
    endfunction

    function automatic logic [7:0] ref_col(int b);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = (b >= 32) ? up_m[k][b-32] : lo_m[k][b];
        return c;
    endfunction

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("R8", "valid_out", 64'(valid_out), 64'(e_vld));
        cmp(e_tag == "R9" ? "R9" : "R1", "chk_gen", 64'(chk_gen), 64'(e_gen));
        cmp(e_tag == "R9" ? "R9" : "R2", "syndrome", 64'(syndrome), 64'(e_syn));
        cmp(e_tag, "data_fault", 64'(data_fault), 64'(e_derr));
        cmp(e_tag, "data_fault_idx", 64'(data_fault_idx), 64'(e_didx));
        cmp(e_tag, "chk_fault", 64'(chk_fault), 64'(e_cerr));
        cmp(e_tag, "chk_fault_idx", 64'(chk_fault_idx), 64'(e_cidx));
        cmp(e_tag, "uncorrectable", 64'(uncorrectable), 64'(e_unc));
        cmp(e_fix_tag, "data_fixed", data_fixed, e_word);
    endtask

    task automatic step(bit v, logic [31:0] h, logic [31:0] l, logic [7:0] c);
        @(negedge clk);
        compare_all();
        valid_in = v; data_hi = h; data_lo = l; chk_stored = c;
        e_vld = v;
        if (v) begin
            int found = -1;
            int ones = 0;
            e_gen = ref_check(h, l);
            e_syn = e_gen ^ c;
            for (int b = 0; b < 64; b++)
                if (found < 0 && e_syn != 0 && ref_col(b) == e_syn) found = b;
            for (int k = 0; k < 8; k++) if (e_syn[k]) ones++;
            e_word = {h, l}; e_derr = 0; e_cerr = 0; e_unc = 0; e_didx = 0; e_cidx = 0;
            if (e_syn == 0) begin
                e_tag = "R5"; e_fix_tag = "R5";
            end else if (found >= 0) begin
                e_derr = 1; e_didx = found; e_word[found] = ~e_word[found];
                e_tag = "R3"; e_fix_tag = "R4";
            end else if (ones == 1) begin
                e_cerr = 1;
                for (int k = 0; k < 8; k++) if (e_syn[k]) e_cidx = k;
                e_tag = "R6"; e_fix_tag = "R6";
            end else begin
                e_unc = 1; e_tag = "R7"; e_fix_tag = "R7";
            end
        end else begin
            e_tag = "R8"; e_fix_tag = "R8";
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] h, l;
        logic [7:0]  g;
        e_vld = 0; e_gen = 0; e_syn = 0; e_derr = 0; e_cerr = 0; e_unc = 0;
        e_didx = 0; e_cidx = 0; e_word = '0; e_tag = "R9"; e_fix_tag = "R9";
        repeat (3) @(negedge clk);
        compare_all();                        // R9 during reset
        rst_n = 1'b1;
        step(0, 32'h0, 32'h0, 8'h0);          // R9 first cycle after release
        // R5 clean words
        step(1, 32'h0, 32'h0, 8'h0);
        step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, ref_check(32'hFFFFFFFF, 32'hFFFFFFFF));
        step(1, 32'hDEADBEEF, 32'h01234567, ref_check(32'hDEADBEEF, 32'h01234567));
        // R3/R4 every single data bit flip
        for (int b = 0; b < 64; b++) begin
            logic [63:0] w = {32'hA5A5_0F0F ^ 32'(b), 32'h3C3C_9999};
            g = ref_check(w[63:32], w[31:0]);
            w[b] = ~w[b];
            step(1, w[63:32], w[31:0], g);
        end
        // R6 every single check bit flip
        for (int k = 0; k < 8; k++) begin
            h = 32'h1357_9BDF; l = 32'h2468_ACE0 + 32'(k);
            step(1, h, l, ref_check(h, l) ^ (8'h1 << k));
        end
        // R7 double data flips
        for (int b = 0; b < 63; b += 7) begin
            logic [63:0] w = {32'h0F0F_F0F0, 32'h5555_AAAA};
            g = ref_check(w[63:32], w[31:0]);
            w[b] = ~w[b]; w[b+1] = ~w[b+1];
            step(1, w[63:32], w[31:0], g);
        end
        // R8 idle cycles with moving inputs: results hold
        step(1, 32'hCAFEF00D, 32'h0BADC0DE, 8'h00);
        step(0, 32'h11111111, 32'h22222222, 8'h33);
        step(0, 32'h44444444, 32'h55555555, 8'h66);
        // random mix
        for (int i = 0; i < 400; i++) begin
            h = $urandom; l = $urandom;
            case (i % 4)
                0: g = ref_check(h, l);
                1: g = ref_check(h, l) ^ (8'h1 << (i % 8));
                2: g = $urandom;
                default: g = ref_check(h ^ (32'h1 << (i % 32)), l);
            endcase
            step((i % 9) != 0, h, l, g);
        end
        step(0, 32'h0, 32'h0, 8'h0);
        step(0, 32'h0, 32'h0, 8'h0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule